// File: doc/BRIEF.md
# Range-Check Table Validator

This block watches a 16-bit lookup table as it streams past, one entry per clock, and decides whether the table is a legal range-check table. A legal table opens with the value 0 and closes with the largest value the width allows, which is 65535 at the default width. Between those two ends, every entry either repeats the entry before it or is one above it. Repeats are allowed because tables are padded with duplicates up to a fixed length, so a legal table may hold more than 2^16 entries. The producer raises an end marker on the final entry. After that entry, the block holds a done flag and a pass/fail verdict until reset.

A second, independent stream carries the values that the table is meant to bound. Any such value at or beyond 2^16 clears a sticky in-range flag. A separate end marker closes that stream. When an entry breaks the step rule, either by jumping more than one or by going down, a sticky error bit is set. The zero-based position of the first such entry is recorded next to it.

Top module: `rc_table_validator`

## Requirements
- R1: After a synchronous active-high reset, table_done, table_ok, step_err and query_done read 0, step_err_idx reads 0 and query_ok reads 1.
- R2: If the first table entry accepted after reset is not 0, table_ok stays 0 at the end of the table.
- R3: If the entry that carries tbl_last is not 2^VAL_W-1 (65535 at the default width), table_ok stays 0.
- R4: A table that starts at 0, ends at 2^VAL_W-1 and only repeats or rises by one gives table_ok = 1. This holds even when repeats make it longer than 2^VAL_W entries.
- R5: The first entry that is below its predecessor, or more than one above it, sets step_err. step_err_idx then holds that entry's zero-based position in the table. Later offending entries change neither output, and table_ok ends at 0.
- R6: table_done rises on the clock edge that accepts the tbl_last entry. Table entries presented after that edge are ignored: table_ok, step_err and step_err_idx keep their values.
- R7: A valid query with a value of 2^VAL_W or more clears query_ok. query_ok stays 0 until reset. Queries from 0 up to 2^VAL_W-1 leave it unchanged.
- R8: query_done rises on the edge that accepts a query with qry_last set. Queries after that edge are ignored, so query_ok keeps its value.
- R9: The table path and the query path are independent. A final table entry and an out-of-range query on the same edge both take effect on that edge.
- R10: All outputs are registered. An input sampled at a clock edge is visible on the outputs only after that edge, never in the cycle where it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tbl_valid | input | 1 | Table entry present this cycle |
| tbl_value | input | VAL_W | Table entry |
| tbl_last | input | 1 | Marks the final table entry |
| qry_valid | input | 1 | Query value present this cycle |
| qry_value | input | QRY_W | Value to be bounded by the table |
| qry_last | input | 1 | Marks the final query |
| table_done | output | 1 | Final table entry has been accepted |
| table_ok | output | 1 | Table verdict, meaningful once table_done is 1 |
| step_err | output | 1 | Sticky step-rule violation |
| step_err_idx | output | IDX_W | Position of the first violating entry |
| query_done | output | 1 | Final query has been accepted |
| query_ok | output | 1 | All accepted queries were in range |

## Verification
Two updates can land on the same clock edge: the table verdict, when the closing entry is accepted, and the clearing of query_ok, when an out-of-range query is accepted. The bench produces this case by driving a legal table whose last entry goes in alongside a query of 300 at an 8-bit table width. It then checks that table_ok reads 1 and query_ok reads 0 after that single edge, and that neither output had changed before it. The step-rule cases use jumps and drops placed at known positions, so that the expected error index can be counted by hand.

// File: rtl/rc_pkg.sv
package rc_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_BAD  = 2'd2
  } step_kind_e;

  // Widened to 32 bits so that max+1 does not wrap back to zero.
  function automatic step_kind_e classify_step(input logic [31:0] prev_v,
                                               input logic [31:0] cur_v);
    if (cur_v == prev_v)            return STEP_HOLD;
    else if (cur_v == prev_v + 1)   return STEP_INC;
    else                            return STEP_BAD;
  endfunction

endpackage

// File: rtl/rc_step_tracker.sv
module rc_step_tracker
  import rc_pkg::*;
#(
  parameter int VAL_W = 16,
  parameter int IDX_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [VAL_W-1:0] value,
  output logic             err_now,
  output logic             start_bad_now,
  output logic             step_err,
  output logic [IDX_W-1:0] step_err_idx
);

  localparam logic [IDX_W-1:0] IDX_SAT = {IDX_W{1'b1}};
  localparam int               PAD_W   = 32 - VAL_W;

  logic [VAL_W-1:0] prev_q;
  logic [IDX_W-1:0] idx_q;
  logic             started_q;
  logic             start_bad_q;
  step_kind_e       kind;
  logic             step_bad;

  assign kind          = classify_step({{PAD_W{1'b0}}, prev_q}, {{PAD_W{1'b0}}, value});
  assign step_bad      = started_q && (kind == STEP_BAD);
  assign err_now       = step_err | (take & step_bad);
  assign start_bad_now = start_bad_q | (take & ~started_q & (value != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q       <= '0;
      idx_q        <= '0;
      started_q    <= 1'b0;
      start_bad_q  <= 1'b0;
      step_err     <= 1'b0;
      step_err_idx <= '0;
    end else if (take) begin
      prev_q    <= value;
      started_q <= 1'b1;
      if (idx_q != IDX_SAT) idx_q <= idx_q + 1'b1;
      if (!started_q && value != '0) start_bad_q <= 1'b1;
      if (step_bad && !step_err) begin
        step_err     <= 1'b1;
        step_err_idx <= idx_q;
      end
    end
  end

endmodule

// File: rtl/rc_table_verdict.sv
module rc_table_verdict #(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             last,
  input  logic [VAL_W-1:0] value,
  input  logic             err_now,
  input  logic             start_bad_now,
  output logic             table_done,
  output logic             table_ok
);

  localparam logic [VAL_W-1:0] TOP_VAL = {VAL_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      table_done <= 1'b0;
      table_ok   <= 1'b0;
    end else if (take && last) begin
      table_done <= 1'b1;
      table_ok   <= ~err_now & ~start_bad_now & (value == TOP_VAL);
    end
  end

endmodule

// File: rtl/rc_query_check.sv
module rc_query_check #(
  parameter int VAL_W = 16,
  parameter int QRY_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             qry_valid,
  input  logic             qry_last,
  input  logic [QRY_W-1:0] qry_value,
  output logic             query_done,
  output logic             query_ok
);

  logic over;
  logic take;

  generate
    if (QRY_W > VAL_W) begin : g_wide
      localparam logic [QRY_W-1:0] TOP_Q = {{(QRY_W-VAL_W){1'b0}}, {VAL_W{1'b1}}};
      assign over = (qry_value > TOP_Q);
    end else begin : g_narrow
      assign over = 1'b0;
    end
  endgenerate

  assign take = qry_valid & ~query_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      query_done <= 1'b0;
      query_ok   <= 1'b1;
    end else if (take) begin
      if (over)     query_ok   <= 1'b0;
      if (qry_last) query_done <= 1'b1;
    end
  end

endmodule

// File: rtl/rc_table_validator.sv
module rc_table_validator #(
  parameter int VAL_W = 16,
  parameter int QRY_W = 32,
  parameter int IDX_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tbl_valid,
  input  logic [VAL_W-1:0] tbl_value,
  input  logic             tbl_last,
  input  logic             qry_valid,
  input  logic [QRY_W-1:0] qry_value,
  input  logic             qry_last,
  output logic             table_done,
  output logic             table_ok,
  output logic             step_err,
  output logic [IDX_W-1:0] step_err_idx,
  output logic             query_done,
  output logic             query_ok
);

  logic tbl_take;
  logic err_now;
  logic start_bad_now;

  assign tbl_take = tbl_valid & ~table_done;

  rc_step_tracker #(.VAL_W(VAL_W), .IDX_W(IDX_W)) u_track (
    .clk           (clk),
    .rst           (rst),
    .take          (tbl_take),
    .value         (tbl_value),
    .err_now       (err_now),
    .start_bad_now (start_bad_now),
    .step_err      (step_err),
    .step_err_idx  (step_err_idx)
  );

  rc_table_verdict #(.VAL_W(VAL_W)) u_verdict (
    .clk           (clk),
    .rst           (rst),
    .take          (tbl_take),
    .last          (tbl_last),
    .value         (tbl_value),
    .err_now       (err_now),
    .start_bad_now (start_bad_now),
    .table_done    (table_done),
    .table_ok      (table_ok)
  );

  rc_query_check #(.VAL_W(VAL_W), .QRY_W(QRY_W)) u_query (
    .clk        (clk),
    .rst        (rst),
    .qry_valid  (qry_valid),
    .qry_last   (qry_last),
    .qry_value  (qry_value),
    .query_done (query_done),
    .query_ok   (query_ok)
  );

endmodule

// File: rtl/rc_table_validator_chk.sv
module rc_table_validator_chk #(
  parameter int VAL_W = 16,
  parameter int QRY_W = 32,
  parameter int IDX_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             tbl_valid,
  input logic [VAL_W-1:0] tbl_value,
  input logic             tbl_last,
  input logic             qry_valid,
  input logic [QRY_W-1:0] qry_value,
  input logic             qry_last,
  input logic             table_done,
  input logic             table_ok,
  input logic             step_err,
  input logic [IDX_W-1:0] step_err_idx,
  input logic             query_done,
  input logic             query_ok
);

  localparam longint      LIM     = (longint'(1) << VAL_W) - 1;
  localparam logic [VAL_W-1:0] TOP_VAL = {VAL_W{1'b1}};

  logic q_over;
  assign q_over = ({{(64-QRY_W){1'b0}}, qry_value} > LIM);

  // R3
  end_value_chk: assert property (@(posedge clk) disable iff (rst)
    (tbl_valid && !table_done && tbl_last && tbl_value != TOP_VAL) |=> !table_ok);

  // R4
  ok_without_err_chk: assert property (@(posedge clk) disable iff (rst)
    table_ok |-> !step_err);

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    step_err |=> step_err);

  // R5
  err_idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    step_err |=> $stable(step_err_idx));

  // R6
  ok_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    table_ok |-> table_done);

  // R6
  verdict_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    table_done |=> (table_done && $stable(table_ok)));

  // R7
  query_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (qry_valid && !query_done && q_over) |=> !query_ok);

  // R7
  query_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !query_ok |=> !query_ok);

  // R8
  query_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    query_done |=> (query_done && $stable(query_ok)));

endmodule

bind rc_table_validator rc_table_validator_chk #(
  .VAL_W(VAL_W), .QRY_W(QRY_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/rc_table_validator_bench.sv
module rc_table_validator_bench;

  localparam int CLK_PERIOD = 10;
  localparam int VAL_W = 8;
  localparam int QRY_W = 12;
  localparam int IDX_W = 12;
  localparam int NVEC  = 8;
  // fields: start, stop, dup_at, jump_at, back_at, exp_ok, exp_err, exp_idx (-1 = none)
  localparam int VEC [0:NVEC-1][0:7] = '{
    '{0, 255, -1, -1, -1, 1, 0,  0},
    '{0, 255, 10, -1, -1, 1, 0,  0},
    '{1, 255, -1, -1, -1, 0, 0,  0},
    '{0, 254, -1, -1, -1, 0, 0,  0},
    '{0, 255, -1, 20, -1, 0, 1, 21},
    '{0, 255, -1, -1, 30, 0, 1, 31},
    '{0, 255, 255, -1, -1, 1, 0, 0},
    '{0, 255,  0, -1, 40, 0, 1, 42}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tbl_valid = 1'b0;
  logic [VAL_W-1:0] tbl_value = '0;
  logic             tbl_last = 1'b0;
  logic             qry_valid = 1'b0;
  logic [QRY_W-1:0] qry_value = '0;
  logic             qry_last = 1'b0;
  logic             table_done, table_ok, step_err, query_done, query_ok;
  logic [IDX_W-1:0] step_err_idx;

  int n_chk  = 0;
  int n_fail = 0;
  int pend_v;
  bit have_pend;
  bit bad_q_at_end;

  always #(CLK_PERIOD/2) clk = ~clk;

  rc_table_validator #(.VAL_W(VAL_W), .QRY_W(QRY_W), .IDX_W(IDX_W)) u_rc_table_validator (
    .clk(clk), .rst(rst),
    .tbl_valid(tbl_valid), .tbl_value(tbl_value), .tbl_last(tbl_last),
    .qry_valid(qry_valid), .qry_value(qry_value), .qry_last(qry_last),
    .table_done(table_done), .table_ok(table_ok),
    .step_err(step_err), .step_err_idx(step_err_idx),
    .query_done(query_done), .query_ok(query_ok)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tbl_valid = 0; tbl_last = 0; qry_valid = 0; qry_last = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    have_pend = 0;
  endtask

  task automatic send_entry(input int v, input bit last);
    @(negedge clk);
    tbl_valid = 1'b1; tbl_value = VAL_W'(v); tbl_last = last;
    if (last && bad_q_at_end) begin
      qry_valid = 1'b1; qry_value = QRY_W'(300); qry_last = 1'b0;
      #1;
      // R10 nothing visible before the sampling edge; R9 query not yet cleared
      check("R10 done before edge", int'(table_done), 0);
      check("R9 query_ok before edge", int'(query_ok), 1);
    end
  endtask

  task automatic push(input int v);
    if (have_pend) send_entry(pend_v, 1'b0);
    pend_v = v;
    have_pend = 1;
  endtask

  task automatic finish_table();
    send_entry(pend_v, 1'b1);
    have_pend = 0;
    @(negedge clk);
    tbl_valid = 0; tbl_last = 0; qry_valid = 0;
  endtask

  task automatic gen_table(input int start, input int stop, input int dup_at,
                           input int jump_at, input int back_at);
    int v;
    v = start;
    while (v <= stop) begin
      push(v);
      if (v == dup_at)  push(v);
      if (v == back_at) push(v - 1);
      if (v == jump_at) v += 2; else v += 1;
    end
    finish_table();
  endtask

  task automatic send_query(input int v, input bit last);
    @(negedge clk);
    qry_valid = 1'b1; qry_value = QRY_W'(v); qry_last = last;
    @(negedge clk);
    qry_valid = 1'b0; qry_last = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    bad_q_at_end = 0;
    do_reset();
    // R1 reset values
    check("R1 table_done", int'(table_done), 0);
    check("R1 table_ok", int'(table_ok), 0);
    check("R1 step_err", int'(step_err), 0);
    check("R1 step_err_idx", int'(step_err_idx), 0);
    check("R1 query_done", int'(query_done), 0);
    check("R1 query_ok", int'(query_ok), 1);

    // Vector walk: R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      do_reset();
      gen_table(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);
      check("R6 table_done", int'(table_done), 1);
      check("R2/R3/R4 table_ok", int'(table_ok), VEC[i][5]);
      check("R5 step_err", int'(step_err), VEC[i][6]);
      if (VEC[i][6] != 0) check("R5 step_err_idx", int'(step_err_idx), VEC[i][7]);
    end

    // R6 entries after the end marker are ignored
    do_reset();
    gen_table(0, 255, -1, -1, -1);
    send_entry(9, 1'b0);
    send_entry(0, 1'b1);
    @(negedge clk); tbl_valid = 0; tbl_last = 0;
    check("R6 ok after extra entries", int'(table_ok), 1);
    check("R6 no err after extra entries", int'(step_err), 0);

    // R4 padding longer than 2^VAL_W entries
    do_reset();
    for (int k = 0; k < 40; k++) push(0);
    for (int v = 0; v <= 255; v++) push(v);
    for (int k = 0; k < 40; k++) push(255);
    finish_table();
    check("R4 padded table ok", int'(table_ok), 1);

    // R7 query range
    do_reset();
    send_query(0, 0);
    send_query(255, 0);
    check("R7 in-range keeps ok", int'(query_ok), 1);
    send_query(256, 0);
    check("R7 256 clears ok", int'(query_ok), 0);
    send_query(3, 0);
    check("R7 stays cleared", int'(query_ok), 0);

    // R8 queries after the last one are ignored
    do_reset();
    send_query(17, 1);
    check("R8 query_done", int'(query_done), 1);
    send_query(4000, 0);
    check("R8 late bad query ignored", int'(query_ok), 1);

    // R9 + R10 same-edge table end and out-of-range query
    do_reset();
    bad_q_at_end = 1;
    gen_table(0, 255, -1, -1, -1);
    bad_q_at_end = 0;
    check("R9 table_ok", int'(table_ok), 1);
    check("R9 query_ok", int'(query_ok), 0);
    check("R10 done after edge", int'(table_done), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule